// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is one channel that sits next to a free-running 16-bit timer. A 4-bit mode field picks what the channel does. In capture mode it copies the timer into a 16-bit holding register when the input pin shows a chosen edge, and it can divide rising edges by 4 or by 16. In compare mode the same 16-bit register is matched against the timer. A match can toggle the output pin, force the pin to a level, only raise the interrupt flag, or send a one-cycle special-event strobe that the system uses to clear the timer and start an ADC conversion. In PWM mode the pin carries a 10-bit duty cycle that repeats over the period of the external timer.

Software reaches the channel through a byte-wide register port. Writes take effect on the next clock edge and reads are combinational. The channel carries no data stream, so it has no valid/ready handshake. Every pin is a plain level or a one-cycle pulse, and a write is accepted in any cycle in which `wr_en` is high. The timer value, its period-reset pulse and the input pin come in as plain signals. The input pin may be asynchronous, because the block synchronises it.

Top module: `tcp_channel`

## Requirements
- R1: Mode codes 0000, 0001 and 0011 turn the channel off. One cycle after the mode is off, the output pin is low. No match or edge sets the flag or the strobe, the prescaler count is zero, and the active PWM duty is cleared.
- R2: Mode 0101 captures on each rising edge and mode 0100 on each falling edge of the input pin. The timer value present two cycles after the pin changes is copied into the holding register, and the flag is set in the same edge. Edges of the other polarity leave the register unchanged.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The rising edges between captures change neither the register nor the flag.
- R4: Every write that changes the mode field clears the edge prescaler, so counting starts again from zero.
- R5: Mode 0010 inverts the output pin on each compare match, one cycle after the timer equals the holding register.
- R6: Entering mode 1000 drives the pin low and a match then drives it high. Entering mode 1001 drives it high and a match drives it low. A later match leaves the forced level unchanged.
- R7: In mode 1010 a match sets the flag and the pin keeps its level.
- R8: In mode 1011 a match sends `special_evt` high for exactly one cycle. No other mode raises `special_evt`.
- R9: A match counts once each time the timer becomes equal to the holding register. The timer staying equal for several cycles gives no further events.
- R10: Any mode code 11xx selects PWM. The duty is {duty byte at address 3, control bits 5:4}. The pin is high in the cycle after a timer whose low 10 bits are below the active duty.
- R11: A new duty becomes active only at `tmr_period` and is already used in that cycle. Between period pulses the active duty does not change.
- R12: Every capture and every compare match sets `irq_flag`, and the flag stays set. Writing 1 to bit 0 at address 4 clears it, and writing 0 does not. A set in the same cycle wins over a clear.
- R13: Register map: address 0 is control, with bits 5:4 the duty LSBs and bits 3:0 the mode; bits 7:6 read as 0. Address 1 is the holding register low byte, address 2 its high byte, address 3 the duty byte and address 4 the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| tmr | input | 16 | Value of the free-running timer |
| tmr_period | input | 1 | Timer period-reset pulse |
| pin_in | input | 1 | Capture input pin, may be asynchronous |
| pin_out | output | 1 | Compare or PWM output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| special_evt | output | 1 | One-cycle special-event strobe |

## Verification
Capture is driven with single edges of each polarity under random timer values, which shows whether the right polarity is selected. Pulse trains of exactly 3 or 15 edges, then one more, test the divide-by-4 and divide-by-16 counts, and a mode change part-way through a train shows whether the prescaler is cleared. Compare runs a random timer sequence that often repeats the match value, so a channel that toggles on every equal cycle differs from one that toggles only on entry into equality. The pin policy of each mode is tried from a starting level that tells the modes apart. PWM is checked against random timer values for two duties, and the duty is rewritten between period pulses to show that the buffered duty does not change before the next period.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam logic [3:0] MODE_TOGGLE = 4'b0010;
  localparam logic [3:0] MODE_FALL   = 4'b0100;
  localparam logic [3:0] MODE_RISE   = 4'b0101;
  localparam logic [3:0] MODE_RISE_A = 4'b0110;
  localparam logic [3:0] MODE_RISE_B = 4'b0111;
  localparam logic [3:0] MODE_SET_HI = 4'b1000;
  localparam logic [3:0] MODE_SET_LO = 4'b1001;
  localparam logic [3:0] MODE_FLAG   = 4'b1010;
  localparam logic [3:0] MODE_EVENT  = 4'b1011;

  function automatic logic is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_pwm(input logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction

  function automatic logic is_cmp(input logic [3:0] m);
    return (m == MODE_TOGGLE) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic is_off(input logic [3:0] m);
    return !(is_cap(m) || is_pwm(m) || is_cmp(m));
  endfunction
endpackage

// File: rtl/tcp_capture.sv
module tcp_capture
  import tcp_pkg::*;
#(
  parameter int SYNC   = 2,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode,
  input  logic       mode_chg,
  input  logic       pin_in,
  output logic       cap_evt
);
  localparam int PRE_W = $clog2(DIV_HI);

  logic [SYNC:0]      sh_q;
  logic [PRE_W-1:0]   cnt_q;
  logic               cur, prv, rise, fall;

  assign cur  = sh_q[SYNC-1];
  assign prv  = sh_q[SYNC];
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    case (mode)
      MODE_FALL:   cap_evt = fall;
      MODE_RISE:   cap_evt = rise;
      MODE_RISE_A: cap_evt = rise && (cnt_q == PRE_W'(DIV_LO - 1));
      MODE_RISE_B: cap_evt = rise && (cnt_q == PRE_W'(DIV_HI - 1));
      default:     cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q <= {sh_q[SYNC-1:0], pin_in};
      if (!is_cap(mode) || mode_chg)
        cnt_q <= '0;
      else if (mode[1] && rise)
        cnt_q <= cap_evt ? '0 : cnt_q + 1'b1;
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RISE_A) |-> (cnt_q < PRE_W'(DIV_LO))); // R3
  AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/tcp_compare.sv
module tcp_compare
  import tcp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode,
  input  logic          mode_chg,
  input  logic [3:0]    next_mode,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] cmp_val,
  output logic          cmp_evt,
  output logic          pin_q,
  output logic          spec_q
);
  logic match_c, match_q;

  assign match_c = is_cmp(mode) && (tmr == cmp_val);
  assign cmp_evt = match_c && !match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      pin_q   <= 1'b0;
      spec_q  <= 1'b0;
    end else begin
      match_q <= match_c;
      spec_q  <= cmp_evt && (mode == MODE_EVENT);
      if (mode_chg && next_mode == MODE_SET_HI)
        pin_q <= 1'b0;
      else if (mode_chg && next_mode == MODE_SET_LO)
        pin_q <= 1'b1;
      else if (is_off(mode))
        pin_q <= 1'b0;
      else if (cmp_evt) begin
        case (mode)
          MODE_TOGGLE: pin_q <= ~pin_q;
          MODE_SET_HI: pin_q <= 1'b1;
          MODE_SET_LO: pin_q <= 1'b0;
          default:     pin_q <= pin_q;
        endcase
      end
    end
  end

  AST_SPEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    spec_q |=> !spec_q); // R8
  AST_FLAG_MODE_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLAG && !mode_chg) |=> $stable(pin_q)); // R7
  AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (is_off(mode) && !mode_chg) |=> !pin_q); // R1
endmodule

// File: rtl/tcp_pwm.sv
module tcp_pwm #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              active,
  input  logic              tmr_period,
  input  logic [DUTY_W-1:0] duty_next,
  input  logic [DUTY_W-1:0] tmr_lo,
  output logic              pwm_q
);
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] duty_use;

  assign duty_use = tmr_period ? duty_next : duty_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (clr)
        duty_act <= '0;
      else if (tmr_period)
        duty_act <= duty_next;
      pwm_q <= active && (tmr_lo < duty_use);
    end
  end

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tmr_period && !clr) |=> $stable(duty_act)); // R11
endmodule

// File: rtl/tcp_channel.sv
module tcp_channel
  import tcp_pkg::*;
#(
  parameter int TW     = 16,
  parameter int DW     = 8,
  parameter int LSB_W  = 2,
  parameter int AW     = 3,
  parameter int SYNC   = 2,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [TW-1:0] tmr,
  input  logic          tmr_period,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          irq_flag,
  output logic          special_evt
);
  localparam int DUTY_W = DW + LSB_W;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_VLO  = AW'(1);
  localparam logic [AW-1:0] A_VHI  = AW'(2);
  localparam logic [AW-1:0] A_DUTY = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);

  logic [3:0]       mode_q;
  logic [LSB_W-1:0] dlsb_q;
  logic [TW-1:0]    val_q;
  logic [DW-1:0]    duty_hi_q;
  logic             flag_q;
  logic             ctrl_wr, mode_chg, flag_clr;
  logic             cap_evt, cmp_evt, cmp_pin, pwm_pin;

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign mode_chg = ctrl_wr && (wr_data[3:0] != mode_q);
  assign flag_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];

  tcp_capture #(.SYNC(SYNC), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_cap (
    .clk(clk), .rst(rst), .mode(mode_q), .mode_chg(mode_chg),
    .pin_in(pin_in), .cap_evt(cap_evt)
  );

  tcp_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst(rst), .mode(mode_q), .mode_chg(mode_chg),
    .next_mode(wr_data[3:0]), .tmr(tmr), .cmp_val(val_q),
    .cmp_evt(cmp_evt), .pin_q(cmp_pin), .spec_q(special_evt)
  );

  tcp_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst), .clr(is_off(mode_q)), .active(is_pwm(mode_q)),
    .tmr_period(tmr_period), .duty_next({duty_hi_q, dlsb_q}),
    .tmr_lo(tmr[DUTY_W-1:0]), .pwm_q(pwm_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      dlsb_q    <= '0;
      val_q     <= '0;
      duty_hi_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= wr_data[3:0];
        dlsb_q <= wr_data[LSB_W+3:4];
      end
      if (wr_en && wr_addr == A_DUTY)
        duty_hi_q <= wr_data;
      if (cap_evt)
        val_q <= tmr;
      else if (wr_en && wr_addr == A_VLO)
        val_q[DW-1:0] <= wr_data;
      else if (wr_en && wr_addr == A_VHI)
        val_q[TW-1:DW] <= wr_data[TW-DW-1:0];
      if (cap_evt || cmp_evt)
        flag_q <= 1'b1;
      else if (flag_clr)
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DW'({dlsb_q, mode_q});
      A_VLO:   rd_data = val_q[DW-1:0];
      A_VHI:   rd_data = DW'(val_q[TW-1:DW]);
      A_DUTY:  rd_data = duty_hi_q;
      A_STAT:  rd_data = DW'(flag_q);
      default: rd_data = '0;
    endcase
  end

  assign pin_out  = is_pwm(mode_q) ? pwm_pin : cmp_pin;
  assign irq_flag = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q); // R12
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (val_q == $past(tmr)) && flag_q); // R2
endmodule

// File: tb/sim_tcp_channel.sv
module sim_tcp_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] tmr = '0;
  logic        tmr_period = 1'b0;
  logic        pin_in = 1'b0;
  logic        pin_out, irq_flag, special_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcp_channel u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr(tmr), .tmr_period(tmr_period),
    .pin_in(pin_in), .pin_out(pin_out), .irq_flag(irq_flag), .special_evt(special_evt)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_val(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic pulse();
    pin_in = 1'b1;
    repeat (3) cyc();
    pin_in = 1'b0;
    repeat (3) cyc();
  endtask

  function automatic logic pwm_exp(input logic [15:0] t, input logic [9:0] d);
    return t[9:0] < d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, t, cv;
    logic        exp_pin, pm, m;
    void'($urandom(32'd1234));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1 reset state
    chk("R1 reset pin", pin_out, 0);
    chk("R1 reset flag", irq_flag, 0);
    chk("R1 reset strobe", special_evt, 0);
    rd(3'd0, b); chk("R13 reset ctrl", b, 8'h00);

    // R2 rising and falling capture
    wr(3'd0, 8'h05);
    tmr = 16'hA5C3; pin_in = 1'b1;
    repeat (3) cyc();
    rd_val(v); chk("R2 rising capture", v, 16'hA5C3);
    chk("R12 flag set by capture", irq_flag, 1);
    wr(3'd4, 8'h00); chk("R12 write 0 keeps flag", irq_flag, 1);
    wr(3'd4, 8'h01); chk("R12 write 1 clears flag", irq_flag, 0);
    wr(3'd0, 8'h04);
    tmr = 16'h5A17; pin_in = 1'b0;
    repeat (3) cyc();
    rd_val(v); chk("R2 falling capture", v, 16'h5A17);
    tmr = 16'h0F0F; pin_in = 1'b1;
    repeat (3) cyc();
    rd_val(v); chk("R2 rising ignored in falling mode", v, 16'h5A17);
    pin_in = 1'b0; repeat (3) cyc();
    wr(3'd0, 8'h05);
    for (int i = 0; i < 6; i++) begin
      t = 16'($urandom);
      tmr = t; pin_in = 1'b1; repeat (3) cyc();
      rd_val(v); chk("R2 random rising capture", v, t);
      tmr = ~t; pin_in = 1'b0; repeat (3) cyc();
      rd_val(v); chk("R2 falling ignored in rising mode", v, t);
    end

    // R3 divide by 4 and 16
    wr(3'd0, 8'h06); wr(3'd4, 8'h01);
    for (int i = 0; i < 3; i++) begin tmr = 16'(100 + i); pulse(); end
    chk("R3 no capture after 3 edges", irq_flag, 0);
    tmr = 16'h0444; pulse();
    chk("R3 capture on 4th edge flag", irq_flag, 1);
    rd_val(v); chk("R3 capture on 4th edge value", v, 16'h0444);
    wr(3'd0, 8'h07); wr(3'd4, 8'h01);
    for (int i = 0; i < 15; i++) begin tmr = 16'(200 + i); pulse(); end
    chk("R3 no capture after 15 edges", irq_flag, 0);
    tmr = 16'h1616; pulse();
    rd_val(v); chk("R3 capture on 16th edge", v, 16'h1616);

    // R4 prescaler clears on mode change
    wr(3'd0, 8'h06); wr(3'd4, 8'h01);
    pulse(); pulse();
    wr(3'd0, 8'h07); wr(3'd0, 8'h06);
    pulse(); pulse(); pulse();
    chk("R4 count restarted after mode change", irq_flag, 0);
    tmr = 16'h0CAF; pulse();
    chk("R4 capture on 4th edge after restart", irq_flag, 1);

    // R5 / R9 toggle
    wr(3'd0, 8'h00);
    cyc(); chk("R1 pin low when off", pin_out, 0);
    tmr = 16'h0000;
    wr(3'd1, 8'h34); wr(3'd2, 8'h12);
    wr(3'd0, 8'h02); wr(3'd4, 8'h01);
    tmr = 16'h1233; cyc(); chk("R5 no match", pin_out, 0);
    tmr = 16'h1234; cyc(); chk("R5 toggle on match", pin_out, 1);
    chk("R12 flag set by match", irq_flag, 1);
    cyc(); chk("R9 held equality no toggle", pin_out, 1);
    tmr = 16'h1235; cyc(); chk("R5 after match", pin_out, 1);
    tmr = 16'h1234; cyc(); chk("R5 second toggle", pin_out, 0);
    tmr = 16'h0000; cyc();
    exp_pin = 1'b0; pm = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tmr = ($urandom % 3 == 0) ? 16'h1234 : 16'($urandom);
      cyc();
      m = (tmr == 16'h1234);
      if (m && !pm) exp_pin = ~exp_pin;
      pm = m;
      chk("R9 R5 random toggle sequence", pin_out, exp_pin);
    end

    // R6 forced levels
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h08); chk("R6 enter 1000 drives low", pin_out, 0);
    tmr = 16'h1234; cyc(); chk("R6 match forces high", pin_out, 1);
    tmr = 16'h0000; cyc(); tmr = 16'h1234; cyc();
    chk("R6 second match keeps high", pin_out, 1);
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h09); chk("R6 enter 1001 drives high", pin_out, 1);
    tmr = 16'h1234; cyc(); chk("R6 match forces low", pin_out, 0);

    // R7 flag-only compare
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h08);
    tmr = 16'h1234; cyc();
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h0A); wr(3'd4, 8'h01);
    tmr = 16'h1234; cyc();
    chk("R7 match sets flag", irq_flag, 1);
    chk("R7 pin unchanged", pin_out, 1);
    chk("R8 no strobe outside 1011", special_evt, 0);

    // R8 special event
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h0B);
    tmr = 16'h1234; cyc(); chk("R8 strobe on match", special_evt, 1);
    cyc(); chk("R8 strobe lasts one cycle", special_evt, 0);

    // R1 reserved codes behave as off
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h09); chk("R6 enter 1001 high", pin_out, 1);
    wr(3'd0, 8'h01); cyc(); chk("R1 code 0001 drives low", pin_out, 0);
    wr(3'd4, 8'h01);
    tmr = 16'h1234; cyc(); cyc();
    chk("R1 no flag in 0001", irq_flag, 0);
    chk("R1 no strobe in 0001", special_evt, 0);
    tmr = 16'h0000; cyc();
    wr(3'd0, 8'h09); wr(3'd0, 8'h03); cyc();
    chk("R1 code 0011 drives low", pin_out, 0);
    tmr = 16'h1234; cyc(); cyc();
    chk("R1 no flag in 0011", irq_flag, 0);

    // R10 / R11 PWM
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h40); wr(3'd0, 8'h2C);
    tmr = 16'h0000; cyc(); chk("R11 duty inactive before period", pin_out, 0);
    tmr_period = 1'b1; cyc(); tmr_period = 1'b0;
    chk("R11 new duty used in period cycle", pin_out, 1);
    for (int i = 0; i < 20; i++) begin
      t = 16'($urandom); tmr = t; cyc();
      chk("R10 pwm duty 258", pin_out, pwm_exp(t, 10'd258));
    end
    wr(3'd3, 8'h10);
    tmr = 16'd100; cyc(); chk("R11 old duty held", pin_out, 1);
    tmr = 16'd0; tmr_period = 1'b1; cyc(); tmr_period = 1'b0;
    chk("R11 period load", pin_out, 1);
    tmr = 16'd100; cyc(); chk("R11 new duty 66", pin_out, 0);
    wr(3'd0, 8'h3F);
    tmr = 16'd0; tmr_period = 1'b1; cyc(); tmr_period = 1'b0;
    for (int i = 0; i < 20; i++) begin
      t = 16'($urandom); tmr = t; cyc();
      chk("R10 pwm code 1111 duty 67", pin_out, pwm_exp(t, 10'd67));
    end
    cv = 16'd66; tmr = cv; cyc(); chk("R10 duty boundary 66", pin_out, 1);
    tmr = 16'd67; cyc(); chk("R10 duty boundary 67", pin_out, 0);

    // R13 unimplemented control bits
    wr(3'd0, 8'hFF);
    rd(3'd0, b); chk("R13 ctrl bits 7:6 read zero", b, 8'h3F);
    rd(3'd3, b); chk("R13 duty byte readback", b, 8'h10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule